// File: doc/BRIEF.md
# Boot Strap Capture and Serial Configuration Fetch

This block decides a chip's start-up configuration while system reset is asserted. Three strap inputs are captured on the final clock edge at which reset is still low. One strap chooses the configuration source. When it is 0, a built-in default image is used and the core leaves reset straight away. When it is 1, the block reads a block of configuration bytes from a serial EEPROM over a two-wire bus. The other two straps change meaning with that choice. With fetching off, they are a boot ROM width code. With fetching on, they are two address bits that pick which EEPROM on the bus to use.

A small sequencer runs the whole read transaction through a byte-level two-wire master. The master's clock is divided down from the system clock, and its data line is modelled as an open-drain pull-down plus an input sample. The core reset output stays asserted until the image is complete. If either address phase gets no acknowledge, an error is recorded and the core stays in reset until the next system reset. The block does not fall back to the defaults.

Top module: `boot_cfg_loader`

## Requirements
- R1: The straps are captured on the last rising clock edge at which `sys_rst_n` is low. Changes on the strap pins after that edge have no effect on `rom_width` or on the load.
- R2: With `strap_fetch_en` captured as 0, `core_rst_n` rises on the first clock edge at which `sys_rst_n` is high. `cfg_image` equals `DEFAULT_IMAGE`, and the bus stays idle (`scl_o` = 1, `sda_oe` = 0).
- R3: With fetching off, `rom_width` shows the captured `strap_sel`: 00 means an 8-bit ROM, 01 a 16-bit ROM, and 10 and 11 are reserved codes passed through unchanged. With fetching on, `rom_width` reads 00.
- R4: With fetching on, the bus carries START, the address byte with write, word address 0x00, repeated START, the address byte with read, `NUM_BYTES` data reads and STOP. The address byte is 1,0,1,0, `strap_sel[1]`, `strap_sel[0]`, 0 and then the read/write bit as its LSB (1 = read).
- R5: The master acknowledges every data byte except the last one, which it answers with a NACK.
- R6: The k-th byte read (k from 0) is stored at `cfg_image[8k+7:8k]`.
- R7: `core_rst_n` rises exactly one clock after the last byte is stored, and never before the last byte's NACK.
- R8: A missing acknowledge on either address byte sets `load_err`. The flag then stays set and `core_rst_n` stays low until the next system reset.
- R9: While `sys_rst_n` is low: `core_rst_n` = 0, `load_err` = 0, `scl_o` = 1, `sda_oe` = 0, and `cfg_image` equals `DEFAULT_IMAGE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| strap_fetch_en | input | 1 | Strap: 1 fetches configuration from EEPROM |
| strap_sel | input | 2 | Strap: ROM width code or EEPROM address bits |
| scl_o | output | 1 | Two-wire bus clock |
| sda_oe | output | 1 | Data line pull-down enable (1 drives low) |
| sda_i | input | 1 | Sampled data line level |
| core_rst_n | output | 1 | Core reset, active low |
| rom_width | output | 2 | Captured boot ROM width code |
| load_err | output | 1 | Sticky address-phase NACK error |
| cfg_image | output | NUM_BYTES*8 | Configuration register image |

## Verification
The strap capture and the hand-over of the strap pins to their run-time use can land on the same clock edge. The bench provokes this by changing `strap_sel` in the last low-reset cycle and again right after release. It then judges `rom_width` and the bus against the value present at the final low edge only. Storing the final byte and releasing the core also meet at one edge. The bench records whether the bus model had already seen the master's closing NACK at the moment `core_rst_n` first reads high.

// File: rtl/bootcfg_pkg.sv
// Shared types for the boot configuration loader.
// Assumes: nothing beyond IEEE 1800-2017.
package bootcfg_pkg;
    // Byte-level bus operations issued by the sequencer.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    // Fixed device-type nibble of the EEPROM address.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Sequencer states.
    typedef enum logic [3:0] {
        S_BOOT, S_START, S_DEVW, S_WORD, S_RSTART,
        S_DEVR, S_DATA, S_STOP, S_FIN
    } seq_state_e;
endpackage

// File: rtl/strap_latch.sv
// Strap capture register.
// Tracks the strap pins on every clock while reset is low, so it ends up
// holding the value from the last edge before release. It is frozen afterwards.
// Assumes: reset is synchronous and held for at least one clock.
module strap_latch #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] q
);
    // Follow pins during reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= pins;
    end
endmodule

// File: rtl/twi_byte_engine.sv
// Byte-level two-wire bus master.
// Each command (START, STOP, WRITE byte, READ byte) is split into bit slots.
// Every slot has four quarter phases of QTR_CYCLES clocks each. A data bit is
// driven while SCL is low and sampled at the end of the first high quarter.
// Outputs are registered. Assumes: QTR_CYCLES >= 2, and a command is only
// presented while busy is low.
module twi_byte_engine
    import bootcfg_pkg::*;
#(
    parameter int QTR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  bus_op_e    cmd_op,
    input  logic [7:0] cmd_data,
    input  logic       cmd_nack,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_data,
    output logic       ack_seen,
    output logic       scl_o,
    output logic       sda_oe,
    input  logic       sda_i
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] QLAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] qcnt;
    logic [1:0]    phase;
    logic [3:0]    bitn;
    bus_op_e       op_q;
    logic [7:0]    sh;
    logic          nack_q;
    logic          qend;
    logic          is_byte;
    logic          scl_n;
    logic          low_n;
    logic          bit_low;

    assign qend    = (qcnt == QLAST);
    assign is_byte = (op_q == OP_WRITE) || (op_q == OP_READ);

    // Step quarter counter, phases and bits; shift data and capture acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            qcnt     <= '0;
            phase    <= 2'd0;
            bitn     <= 4'd0;
            op_q     <= OP_START;
            sh       <= 8'h00;
            nack_q   <= 1'b0;
            rx_data  <= 8'h00;
            ack_seen <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (cmd_valid) begin
                    busy   <= 1'b1;
                    op_q   <= cmd_op;
                    sh     <= cmd_data;
                    nack_q <= cmd_nack;
                    qcnt   <= '0;
                    phase  <= 2'd0;
                    bitn   <= 4'd0;
                end
            end else if (!qend) begin
                qcnt <= qcnt + 1'b1;
            end else begin
                qcnt  <= '0;
                phase <= phase + 2'd1;
                if (phase == 2'd1 && is_byte) begin
                    if (bitn == 4'd8)          ack_seen <= !sda_i;
                    else if (op_q == OP_READ)  sh <= {sh[6:0], sda_i};
                end
                if (phase == 2'd3) begin
                    if (!is_byte || bitn == 4'd8) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        rx_data <= sh;
                    end else begin
                        bitn <= bitn + 4'd1;
                        if (op_q == OP_WRITE) sh <= {sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // Data-line level wanted during a bit slot of a byte command.
    always_comb begin
        if (bitn == 4'd8) bit_low = (op_q == OP_READ) ? !nack_q : 1'b0;
        else              bit_low = (op_q == OP_WRITE) ? !sh[7] : 1'b0;
    end

    // Decode phase into the next bus levels; hold the levels while idle.
    always_comb begin
        scl_n = scl_o;
        low_n = sda_oe;
        if (busy) begin
            unique case (op_q)
                OP_START: begin
                    scl_n = (phase == 2'd1) || (phase == 2'd2);
                    low_n = (phase >= 2'd2);
                end
                OP_STOP: begin
                    scl_n = (phase != 2'd0);
                    low_n = (phase <= 2'd1);
                end
                default: begin
                    scl_n = (phase == 2'd1) || (phase == 2'd2);
                    low_n = bit_low;
                end
            endcase
        end
    end

    // Register bus outputs; released bus after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_o  <= 1'b1;
            sda_oe <= 1'b0;
        end else begin
            scl_o  <= scl_n;
            sda_oe <= low_n;
        end
    end
endmodule

// File: rtl/cfg_fetch_seq.sv
// Load sequencer.
// After reset it either finishes at once (fetching off) or walks the EEPROM
// read transaction: START, address+write, word 0x00, repeated START,
// address+read, NUM_BYTES reads (the last one NACKed), STOP. Each received
// byte is offered for storage. A NACK on an address byte sets a sticky
// error and ends with STOP. Assumes: the engine raises done for exactly one
// clock, in the same edge that busy falls.
module cfg_fetch_seq
    import bootcfg_pkg::*;
#(
    parameter int NUM_BYTES = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fetch_en,
    input  logic [1:0]                   addr_sel,
    input  logic                         eng_busy,
    input  logic                         eng_done,
    input  logic [7:0]                   eng_rx,
    input  logic                         eng_ack,
    output logic                         cmd_valid,
    output bus_op_e                      cmd_op,
    output logic [7:0]                   cmd_data,
    output logic                         cmd_nack,
    output logic                         byte_we,
    output logic [$clog2(NUM_BYTES)-1:0] byte_idx,
    output logic [7:0]                   byte_val,
    output logic                         load_ok,
    output logic                         load_err
);
    localparam int IW = $clog2(NUM_BYTES);
    localparam logic [IW-1:0] LAST = IW'(NUM_BYTES - 1);

    seq_state_e    st;
    logic          issued;
    logic [IW-1:0] cnt;
    logic          active;
    logic [6:0]    dev_addr;

    assign active   = (st != S_BOOT) && (st != S_FIN);
    assign dev_addr = {DEV_TYPE, addr_sel, 1'b0};

    // Advance through the transaction and record the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_BOOT;
            issued   <= 1'b0;
            cnt      <= '0;
            load_ok  <= 1'b0;
            load_err <= 1'b0;
        end else if (st == S_BOOT) begin
            st <= fetch_en ? S_START : S_FIN;
        end else if (active) begin
            if (!issued && !eng_busy) issued <= 1'b1;
            if (eng_done) begin
                issued <= 1'b0;
                unique case (st)
                    S_START:  st <= S_DEVW;
                    S_DEVW:   begin
                        if (eng_ack) st <= S_WORD;
                        else begin load_err <= 1'b1; st <= S_STOP; end
                    end
                    S_WORD:   st <= S_RSTART;
                    S_RSTART: st <= S_DEVR;
                    S_DEVR:   begin
                        if (eng_ack) st <= S_DATA;
                        else begin load_err <= 1'b1; st <= S_STOP; end
                    end
                    S_DATA:   begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            load_ok <= 1'b1;
                            st      <= S_STOP;
                        end
                    end
                    S_STOP:   st <= S_FIN;
                    default:  st <= S_FIN;
                endcase
            end
        end
    end

    // Command for the current state.
    always_comb begin
        cmd_valid = active && !issued && !eng_busy;
        cmd_nack  = (cnt == LAST);
        cmd_data  = 8'h00;
        unique case (st)
            S_START, S_RSTART: cmd_op = OP_START;
            S_DEVW:  begin cmd_op = OP_WRITE; cmd_data = {dev_addr, 1'b0}; end
            S_WORD:  begin cmd_op = OP_WRITE; cmd_data = 8'h00; end
            S_DEVR:  begin cmd_op = OP_WRITE; cmd_data = {dev_addr, 1'b1}; end
            S_DATA:  cmd_op = OP_READ;
            default: cmd_op = OP_STOP;
        endcase
    end

    // Offer each received data byte for storage.
    assign byte_we  = (st == S_DATA) && eng_done;
    assign byte_idx = cnt;
    assign byte_val = eng_rx;
endmodule

// File: rtl/boot_cfg_loader.sv
// Top level: strap capture, load sequencer, two-wire master and image register.
// The core reset is released once the configuration is settled. That is the
// first clock after system reset when fetching is off, or one clock after the
// last byte is stored when it is on. It is never released after an address
// NACK. Assumes: sys_rst_n is synchronous to clk.
module boot_cfg_loader
    import bootcfg_pkg::*;
#(
    parameter int NUM_BYTES  = 32,
    parameter int QTR_CYCLES = 4,
    parameter logic [NUM_BYTES*8-1:0] DEFAULT_IMAGE = {NUM_BYTES{8'h3C}}
) (
    input  logic                   clk,
    input  logic                   sys_rst_n,
    input  logic                   strap_fetch_en,
    input  logic [1:0]             strap_sel,
    output logic                   scl_o,
    output logic                   sda_oe,
    input  logic                   sda_i,
    output logic                   core_rst_n,
    output logic [1:0]             rom_width,
    output logic                   load_err,
    output logic [NUM_BYTES*8-1:0] cfg_image
);
    localparam int IW = $clog2(NUM_BYTES);

    logic [2:0]    straps_q;
    logic          fetch_en_q;
    logic [1:0]    sel_q;
    logic          cmd_valid;
    bus_op_e       cmd_op;
    logic [7:0]    cmd_data;
    logic          cmd_nack;
    logic          eng_busy;
    logic          eng_done;
    logic [7:0]    eng_rx;
    logic          eng_ack;
    logic          byte_we;
    logic [IW-1:0] byte_idx;
    logic [7:0]    byte_val;
    logic          load_ok;

    strap_latch #(.WIDTH(3)) u_straps (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .pins  ({strap_fetch_en, strap_sel}),
        .q     (straps_q)
    );

    assign fetch_en_q = straps_q[2];
    assign sel_q      = straps_q[1:0];
    assign rom_width  = fetch_en_q ? 2'b00 : sel_q;

    cfg_fetch_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .fetch_en  (fetch_en_q),
        .addr_sel  (sel_q),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx),
        .eng_ack   (eng_ack),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .cmd_nack  (cmd_nack),
        .byte_we   (byte_we),
        .byte_idx  (byte_idx),
        .byte_val  (byte_val),
        .load_ok   (load_ok),
        .load_err  (load_err)
    );

    twi_byte_engine #(.QTR_CYCLES(QTR_CYCLES)) u_eng (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .cmd_nack  (cmd_nack),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_data   (eng_rx),
        .ack_seen  (eng_ack),
        .scl_o     (scl_o),
        .sda_oe    (sda_oe),
        .sda_i     (sda_i)
    );

    // Image register: defaults in reset, then overwritten byte by byte.
    always_ff @(posedge clk) begin
        if (!sys_rst_n)   cfg_image <= DEFAULT_IMAGE;
        else if (byte_we) cfg_image[byte_idx*8 +: 8] <= byte_val;
    end

    // Core reset release once the configuration is settled.
    always_ff @(posedge clk) begin
        if (!sys_rst_n)                  core_rst_n <= 1'b0;
        else if (!fetch_en_q || load_ok) core_rst_n <= 1'b1;
    end
endmodule

// File: rtl/bootcfg_checker.sv
// Assertion checker for boot_cfg_loader, attached with bind below.
// Assumes: sys_rst_n is asserted from time zero.
module bootcfg_checker (
    input logic       clk,
    input logic       sys_rst_n,
    input logic       core_rst_n,
    input logic       load_err,
    input logic [1:0] rom_width,
    input logic       scl_o,
    input logic       sda_oe,
    input logic       fetch_en_q,
    input logic       load_ok
);
    // R9: the core is held while system reset is low.
    p_core_held_r9: assert property (@(posedge clk)
        !sys_rst_n |=> !core_rst_n);

    // R2: with fetching off, the core is out one edge after release.
    p_fast_release_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (!fetch_en_q && !$past(sys_rst_n)) |=> core_rst_n);

    // R2: with fetching off, the bus stays idle.
    p_bus_quiet_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !fetch_en_q |-> (scl_o && !sda_oe));

    // R1: the captured width does not move after release.
    p_width_frozen_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $past(sys_rst_n) |-> $stable(rom_width));

    // R8: the error is sticky and keeps the core in reset.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        load_err |=> load_err);
    p_err_holds_core_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        load_err |-> !core_rst_n);

    // R7: release comes exactly one clock after the final store.
    p_release_timing_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(load_ok) |-> (!core_rst_n ##1 core_rst_n));

    // R7: once released, the core stays out of reset.
    p_release_sticky_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        core_rst_n |=> core_rst_n);
endmodule

bind boot_cfg_loader bootcfg_checker u_chk (
    .clk        (clk),
    .sys_rst_n  (sys_rst_n),
    .core_rst_n (core_rst_n),
    .load_err   (load_err),
    .rom_width  (rom_width),
    .scl_o      (scl_o),
    .sda_oe     (sda_oe),
    .fetch_en_q (fetch_en_q),
    .load_ok    (load_ok)
);

// File: tb/boot_cfg_loader_test.sv
// Bench for boot_cfg_loader: a vector table walked by one loop, then directed
// strap-timing checks. Includes a behavioural EEPROM bus model.
module boot_cfg_loader_test;
    localparam int NB  = 32;
    localparam int QTR = 4;
    localparam logic [NB*8-1:0] DEF = {NB{8'hC3}};
    localparam int WD_LIMIT = 190000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          sys_rst_n = 1'b0;
    logic          strap_fetch_en = 1'b0;
    logic [1:0]    strap_sel = 2'b00;
    logic          scl_o, sda_oe, sda_i, core_rst_n, load_err;
    logic [1:0]    rom_width;
    logic [NB*8-1:0] cfg_image;
    logic          slv_pull = 1'b0;

    assign sda_i = !(sda_oe || slv_pull);

    boot_cfg_loader #(.NUM_BYTES(NB), .QTR_CYCLES(QTR), .DEFAULT_IMAGE(DEF)) uut (
        .clk(clk), .sys_rst_n(sys_rst_n), .strap_fetch_en(strap_fetch_en),
        .strap_sel(strap_sel), .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i),
        .core_rst_n(core_rst_n), .rom_width(rom_width), .load_err(load_err),
        .cfg_image(cfg_image)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    function automatic logic [7:0] memb(input int i);
        return 8'((i * 29 + 11) & 255) ^ 8'h5A;
    endfunction

    function automatic logic [NB*8-1:0] exp_image();
        logic [NB*8-1:0] img;
        for (int k = 0; k < NB; k++) img[k*8 +: 8] = memb(k);
        return img;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Behavioural EEPROM bus model.
    logic       present = 1'b0;
    logic [1:0] slv_sel = 2'b00;
    int  bcnt, starts, stops, acks, nacks, ph;
    bit  rd, go_read, m_ack, p_scl, p_sda;
    logic [7:0] sh, cur, ptr, word_rx;
    logic [7:0] addr_log [2];

    always @(negedge clk) begin
        bit c_scl, c_sda;
        c_scl = scl_o;
        c_sda = sda_i;
        if (!sys_rst_n) begin
            bcnt = 0; starts = 0; stops = 0; acks = 0; nacks = 0; ph = 3;
            rd = 0; go_read = 0; m_ack = 0; slv_pull = 1'b0; ptr = 8'h00;
            word_rx = 8'hFF; addr_log[0] = 8'h00; addr_log[1] = 8'h00;
        end else if (p_scl && c_scl && p_sda && !c_sda) begin
            if (starts < 2) addr_log[starts] = 8'h00;
            starts++; bcnt = 0; rd = 0; go_read = 0; ph = 0; slv_pull = 1'b0;
        end else if (p_scl && c_scl && !p_sda && c_sda) begin
            stops++; ph = 3; rd = 0; slv_pull = 1'b0;
        end else if (!p_scl && c_scl) begin
            bcnt++;
            if (!rd && bcnt <= 8) sh = {sh[6:0], c_sda};
            if (rd && bcnt == 9) m_ack = !c_sda;
        end else if (p_scl && !c_scl) begin
            if (bcnt == 8) begin
                slv_pull = 1'b0;
                if (!rd) begin
                    if (ph == 0) begin
                        if (starts <= 2) addr_log[starts-1] = sh;
                        if (present && sh[7:1] == {4'b1010, slv_sel, 1'b0}) begin
                            slv_pull = 1'b1;
                            if (sh[0]) go_read = 1; else ph = 1;
                        end else ph = 3;
                    end else if (ph == 1) begin
                        word_rx = sh; ptr = sh; slv_pull = 1'b1; ph = 2;
                    end
                end
            end else if (bcnt == 9) begin
                bcnt = 0; slv_pull = 1'b0;
                if (go_read) begin
                    go_read = 0; rd = 1; cur = memb(int'(ptr)); ptr++;
                    slv_pull = !cur[7];
                end else if (rd) begin
                    if (m_ack) begin
                        acks++; cur = memb(int'(ptr)); ptr++; slv_pull = !cur[7];
                    end else begin
                        nacks++; rd = 0; ph = 3;
                    end
                end
            end else if (rd && bcnt >= 1 && bcnt <= 7) begin
                slv_pull = !cur[7-bcnt];
            end
        end
        p_scl = c_scl;
        p_sda = c_sda;
    end

    task automatic apply_reset(input logic en, input logic [1:0] sel);
        @(negedge clk);
        sys_rst_n = 1'b0; strap_fetch_en = en; strap_sel = sel;
        repeat (6) @(negedge clk);
        sys_rst_n = 1'b1;
    endtask

    // Vector: {fetch_en, sel[1:0], present, slave_sel[1:0], expect_err}
    localparam logic [6:0] VECS [7] = '{
        7'b0_00_0_00_0,
        7'b0_01_0_00_0,
        7'b0_11_0_00_0,
        7'b1_00_1_00_0,
        7'b1_11_1_11_0,
        7'b1_10_0_10_1,
        7'b1_01_1_10_1
    };

    initial begin
        // R9: reset state.
        repeat (4) @(negedge clk);
        check(core_rst_n == 1'b0 && load_err == 1'b0, "R9 core/err in reset",
              {core_rst_n, load_err}, 0);
        check(scl_o == 1'b1 && sda_oe == 1'b0, "R9 bus idle in reset",
              {scl_o, sda_oe}, 2'b10);
        check(cfg_image == DEF, "R9 image default in reset", cfg_image, DEF);

        for (int v = 0; v < 7; v++) begin
            logic en, perr;
            logic [1:0] sel;
            int waited, nacks_at_rel;
            bit quiet;
            en = VECS[v][6]; sel = VECS[v][5:4]; present = VECS[v][3];
            slv_sel = VECS[v][2:1]; perr = VECS[v][0];
            apply_reset(en, sel);
            if (!en) begin
                check(core_rst_n == 1'b0, "R2 held before first edge", core_rst_n, 0);
                @(negedge clk);
                check(core_rst_n == 1'b1, "R2 release on first edge", core_rst_n, 1);
                check(cfg_image == DEF, "R2 default image", cfg_image, DEF);
                quiet = 1;
                repeat (60) begin
                    @(negedge clk);
                    if (!scl_o || sda_oe) quiet = 0;
                end
                check(quiet, "R2 bus idle when fetch off", quiet, 1);
            end else begin
                waited = 0;
                while (!core_rst_n && !load_err && waited < 20000) begin
                    @(negedge clk); waited++;
                end
                nacks_at_rel = nacks;
                if (perr) begin
                    check(load_err == 1'b1 && core_rst_n == 1'b0, "R8 nack sets error",
                          {load_err, core_rst_n}, 2'b10);
                    repeat (800) @(negedge clk);
                    check(load_err == 1'b1 && core_rst_n == 1'b0, "R8 error sticky",
                          {load_err, core_rst_n}, 2'b10);
                    check(cfg_image == DEF, "R8 image untouched", cfg_image, DEF);
                end else begin
                    check(core_rst_n == 1'b1 && load_err == 1'b0, "R7 core released",
                          {core_rst_n, load_err}, 2'b10);
                    check(nacks_at_rel == 1, "R7 not before last NACK", nacks_at_rel, 1);
                    check(cfg_image == exp_image(), "R6 image bytes", cfg_image, exp_image());
                    repeat (300) @(negedge clk);
                    check(acks == NB - 1 && nacks == 1, "R5 ack/nack pattern",
                          {acks, nacks}, {NB - 1, 1});
                    check(addr_log[0] == {4'b1010, sel, 2'b00}, "R4 write address byte",
                          addr_log[0], {4'b1010, sel, 2'b00});
                    check(addr_log[1] == {4'b1010, sel, 2'b01}, "R4 read address byte",
                          addr_log[1], {4'b1010, sel, 2'b01});
                    check(word_rx == 8'h00 && starts == 2 && stops == 1,
                          "R4 word addr, starts, stop", {word_rx, 8'(starts), 8'(stops)},
                          {8'h00, 8'd2, 8'd1});
                end
            end
            check(rom_width == (en ? 2'b00 : sel), "R3 width code", rom_width,
                  en ? 2'b00 : sel);
        end

        // R1: capture uses the last low-reset edge; later pin changes ignored.
        @(negedge clk);
        sys_rst_n = 1'b0; strap_fetch_en = 1'b0; strap_sel = 2'b11;
        repeat (5) @(negedge clk);
        strap_sel = 2'b01;
        @(negedge clk);
        sys_rst_n = 1'b1;
        strap_sel = 2'b10;
        strap_fetch_en = 1'b1;
        repeat (3) @(negedge clk);
        check(rom_width == 2'b01, "R1 last-edge capture", rom_width, 2'b01);
        check(core_rst_n == 1'b1 && scl_o == 1'b1 && sda_oe == 1'b0,
              "R1 fetch pin change after release ignored",
              {core_rst_n, scl_o, sda_oe}, 3'b110);
        repeat (100) @(negedge clk);
        check(rom_width == 2'b01 && load_err == 1'b0, "R1 width stays frozen",
              {rom_width, load_err}, 3'b010);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule